// File: doc/BRIEF.md
# Trigger-Started Exposure Sequencer

This block runs exposure that starts from an external trigger instead of following vertical sync. It belongs in a camera timing generator. While the mode is enabled and no trigger has arrived, the block is armed. In that state it pulses the sensor discharge output once per line so that charge never builds up, and it holds back the readout pulse. The vertical transfer clocks are produced elsewhere and keep running.

A falling edge on the asynchronous trigger input is first passed through a flop synchronizer. The block then raises a one-cycle request that resets the horizontal line counter, so the vertical clocks, clamp and blanking pulses start again from that point. In the same cycle it issues one last discharge pulse, and exposure starts there. The block then counts the programmed number of line ticks. It fires the readout pulse and a matching frame-memory write-enable pulse, whatever the phase of vertical sync, and then arms again. Further triggers are ignored while an exposure is under way. A level output tells the sync generator to halt its vertical functions for as long as the mode is active.

Top module: `trig_expo_seq`

## Requirements
- R1: While reset is asserted and in the first cycles after its release, hd_reset, discharge, readout, wr_en and vsync_halt are all 0.
- R2: vsync_halt is 1 from the cycle after mode_en is first sampled high, and it returns to 0 the cycle after mode_en is sampled low.
- R3: While armed, each line_tick sampled high produces a one-cycle discharge pulse in the following cycle, and readout and wr_en stay 0.
- R4: A falling edge of trig_in is synchronized through SYNC_STAGES flops (default 2). If trig_in is first sampled low at rising edge k, hd_reset and discharge are both high for exactly one cycle after edge k+SYNC_STAGES.
- R5: From the cycle after that final discharge until readout, discharge stays 0 even though line ticks arrive.
- R6: readout and wr_en pulse together for one cycle, in the cycle after the N-th line_tick that follows the trigger. N is the expo_lines value sampled at the trigger, and a value of 0 acts as 1.
- R7: Changes to expo_lines after the trigger has been accepted do not change the length of the exposure under way.
- R8: Falling trigger edges during an exposure produce no hd_reset and no discharge. After readout the block is armed again: discharge resumes on line ticks and a new trigger is accepted.
- R9: With mode_en low, all pulse outputs stay 0 and triggers are ignored. Dropping mode_en during an exposure abandons it, and on re-enable the block is armed with no readout pending.
- R10: A rising edge of trig_in has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mode_en | input | 1 | Enables trigger-started exposure mode |
| trig_in | input | 1 | Asynchronous external trigger, active on its falling edge |
| line_tick | input | 1 | One-cycle pulse once per horizontal line |
| expo_lines | input | EXP_W | Exposure length in lines (0 acts as 1) |
| hd_reset | output | 1 | One-cycle request to reset horizontal timing |
| discharge | output | 1 | One-cycle sensor discharge pulse |
| readout | output | 1 | One-cycle readout (charge transfer) pulse |
| wr_en | output | 1 | One-cycle frame-memory write-enable pulse, paired with readout |
| vsync_halt | output | 1 | High while vertical sync functions must halt |

## Verification
The bench builds the block with EXP_W set to 4 and SYNC_STAGES left at 2. This makes it possible to sweep every exposure length from 0 to 15 and count the exact line on which readout lands for each one. Each sweep run also rewrites expo_lines after the trigger and pulses the trigger mid-exposure, to show that both are ignored. The two-stage synchronizer gives a fixed, small latency, so the cycle of the hd_reset and discharge pulses can be checked cycle by cycle, along with abort and re-arm through mode_en.

// File: rtl/trig_expo_pkg.sv
package trig_expo_pkg;
  typedef enum logic [1:0] {
    SQ_OFF    = 2'd0,
    SQ_ARMED  = 2'd1,
    SQ_EXPOSE = 2'd2
  } seq_state_e;
endpackage

// File: rtl/trig_rst_sync.sv
module trig_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] meta_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) meta_q <= 2'b00;
    else         meta_q <= {meta_q[0], 1'b1};
  end

  assign srst_n = meta_q[1];
endmodule

// File: rtl/trig_sync_edge.sv
module trig_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic fall_o
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  // Idle level of the trigger is high, so the chain resets to ones.
  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= async_in;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= {chain_q[STAGES-2:0], async_in};
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= chain_q[STAGES-1];
  end

  assign fall_o = prev_q & ~chain_q[STAGES-1];

  // R4: a falling edge is reported for a single cycle only
  p_fall_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fall_o |=> !fall_o);
endmodule

// File: rtl/expo_line_cnt.sv
module expo_line_cnt #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic         run_i,
  input  logic         tick_i,
  input  logic [W-1:0] len_i,
  output logic         done_o
);
  logic [W-1:0] tgt_q, tgt_n;
  logic [W-1:0] cnt_q, cnt_n;
  logic         cnt_en;

  always_comb begin
    tgt_n  = (len_i == '0) ? W'(1) : len_i;
    cnt_en = start_i | (run_i & tick_i);
    cnt_n  = start_i ? '0 : cnt_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgt_q <= W'(1);
    end else if (start_i) begin
      tgt_q <= tgt_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_n;
    end
  end

  assign done_o = run_i & tick_i & (cnt_q == tgt_q - W'(1));

  // R6: the line count never passes the latched target during exposure
  p_cnt_in_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    run_i |-> (cnt_q < tgt_q));
  // R7: the target stays put while counting
  p_tgt_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && $past(run_i)) |-> $stable(tgt_q));
endmodule

// File: rtl/trig_expo_ctrl.sv
module trig_expo_ctrl
  import trig_expo_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic mode_en,
  input  logic fall_i,
  input  logic tick_i,
  input  logic done_i,
  output logic start_o,
  output logic run_o,
  output logic hd_reset_o,
  output logic discharge_o,
  output logic readout_o,
  output logic wr_en_o,
  output logic halt_o
);
  seq_state_e state_q, state_n;
  logic hd_n, dis_n, rd_n, halt_n;

  always_comb begin
    state_n = state_q;
    if (!mode_en) begin
      state_n = SQ_OFF;
    end else begin
      unique case (state_q)
        SQ_OFF:    state_n = SQ_ARMED;
        SQ_ARMED:  if (fall_i) state_n = SQ_EXPOSE;
        SQ_EXPOSE: if (done_i) state_n = SQ_ARMED;
        default:   state_n = SQ_OFF;
      endcase
    end
    hd_n    = mode_en & (state_q == SQ_ARMED) & fall_i;
    dis_n   = mode_en & (state_q == SQ_ARMED) & (fall_i | tick_i);
    rd_n    = mode_en & (state_q == SQ_EXPOSE) & done_i;
    halt_n  = mode_en;
    start_o = hd_n;
    run_o   = (state_q == SQ_EXPOSE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= SQ_OFF;
      hd_reset_o  <= 1'b0;
      discharge_o <= 1'b0;
      readout_o   <= 1'b0;
      wr_en_o     <= 1'b0;
      halt_o      <= 1'b0;
    end else begin
      state_q     <= state_n;
      hd_reset_o  <= hd_n;
      discharge_o <= dis_n;
      readout_o   <= rd_n;
      wr_en_o     <= rd_n;
      halt_o      <= halt_n;
    end
  end

  // R4: the horizontal reset request always carries the final discharge
  p_hd_with_dis_r4: assert property (@(posedge clk) disable iff (!rst_n)
    hd_reset_o |-> discharge_o);
  // R5: no discharge once exposure is under way
  p_no_dis_expose_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state_q) == SQ_EXPOSE && state_q == SQ_EXPOSE) |-> !discharge_o);
  // R3: readout held off while armed
  p_no_rd_armed_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state_q) == SQ_ARMED && state_q == SQ_ARMED) |-> !readout_o);
  // R6: readout only follows a line tick
  p_rd_after_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
    readout_o |-> $past(tick_i));
  // R9: everything quiet while the mode is off
  p_quiet_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !halt_o |-> !(hd_reset_o | discharge_o | readout_o | wr_en_o));
endmodule

// File: rtl/trig_expo_seq.sv
module trig_expo_seq #(
  parameter int EXP_W       = 9,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_en,
  input  logic             trig_in,
  input  logic             line_tick,
  input  logic [EXP_W-1:0] expo_lines,
  output logic             hd_reset,
  output logic             discharge,
  output logic             readout,
  output logic             wr_en,
  output logic             vsync_halt
);
  logic srst_n;
  logic trig_fall;
  logic cnt_start, cnt_run, cnt_done;

  trig_rst_sync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  trig_sync_edge #(.STAGES(SYNC_STAGES)) u_edge (
    .clk      (clk),
    .rst_n    (srst_n),
    .async_in (trig_in),
    .fall_o   (trig_fall)
  );

  expo_line_cnt #(.W(EXP_W)) u_cnt (
    .clk     (clk),
    .rst_n   (srst_n),
    .start_i (cnt_start),
    .run_i   (cnt_run),
    .tick_i  (line_tick),
    .len_i   (expo_lines),
    .done_o  (cnt_done)
  );

  trig_expo_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (srst_n),
    .mode_en     (mode_en),
    .fall_i      (trig_fall),
    .tick_i      (line_tick),
    .done_i      (cnt_done),
    .start_o     (cnt_start),
    .run_o       (cnt_run),
    .hd_reset_o  (hd_reset),
    .discharge_o (discharge),
    .readout_o   (readout),
    .wr_en_o     (wr_en),
    .halt_o      (vsync_halt)
  );

  // R6: write enable and readout always appear together
  p_we_pairs_rd_r6: assert property (@(posedge clk) disable iff (!srst_n)
    wr_en == readout);
endmodule

// File: tb/trig_expo_seq_tb.sv
module trig_expo_seq_tb;
  localparam int W = 4;

  logic         clk = 1'b0;
  logic         rst_n, mode_en, trig_in, line_tick;
  logic [W-1:0] expo_lines;
  logic         hd_reset, discharge, readout, wr_en, vsync_halt;
  int           total = 0;
  int           bad = 0;
  bit           finished = 1'b0;

  always #2 clk = ~clk;

  trig_expo_seq #(.EXP_W(W), .SYNC_STAGES(2)) u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_en    (mode_en),
    .trig_in    (trig_in),
    .line_tick  (line_tick),
    .expo_lines (expo_lines),
    .hd_reset   (hd_reset),
    .discharge  (discharge),
    .readout    (readout),
    .wr_en      (wr_en),
    .vsync_halt (vsync_halt)
  );

  task automatic chk(input logic got, input logic exp, input string tag);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%0b exp=%0b", tag, got, exp);
    end
  endtask

  task automatic idle_chk(input logic e_hd, input logic e_dis, input logic e_rd,
                          input string tag);
    @(negedge clk);
    chk(hd_reset, e_hd, {tag, " hd_reset"});
    chk(discharge, e_dis, {tag, " discharge"});
    chk(readout, e_rd, {tag, " readout"});
    chk(wr_en, e_rd, {tag, " wr_en"});
  endtask

  task automatic tick_chk(input logic e_dis, input logic e_rd, input string tag);
    @(negedge clk) line_tick = 1'b1;
    @(negedge clk) line_tick = 1'b0;
    chk(discharge, e_dis, {tag, " discharge"});
    chk(readout, e_rd, {tag, " readout"});
    chk(wr_en, e_rd, {tag, " wr_en"});
    chk(hd_reset, 1'b0, {tag, " hd_reset"});
  endtask

  // Accepted trigger: pulses land after the third rising edge
  task automatic trig_accept(input string tag);
    @(negedge clk) trig_in = 1'b0;
    idle_chk(1'b0, 1'b0, 1'b0, {tag, " R4 latency1"});
    idle_chk(1'b0, 1'b0, 1'b0, {tag, " R4 latency2"});
    idle_chk(1'b1, 1'b1, 1'b0, {tag, " R4 pulse"});
    idle_chk(1'b0, 1'b0, 1'b0, {tag, " R4 width"});
    trig_in = 1'b1;
    for (int i = 0; i < 4; i++) idle_chk(1'b0, 1'b0, 1'b0, {tag, " R10 rise"});
  endtask

  task automatic trig_ignored(input string tag);
    @(negedge clk) trig_in = 1'b0;
    for (int i = 0; i < 4; i++) idle_chk(1'b0, 1'b0, 1'b0, tag);
    trig_in = 1'b1;
    for (int i = 0; i < 4; i++) idle_chk(1'b0, 1'b0, 1'b0, tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; mode_en = 1'b0; trig_in = 1'b1; line_tick = 1'b0;
    expo_lines = '0;
    repeat (3) idle_chk(1'b0, 1'b0, 1'b0, "R1 in reset");
    chk(vsync_halt, 1'b0, "R1 vsync_halt");
    rst_n = 1'b1;
    repeat (4) idle_chk(1'b0, 1'b0, 1'b0, "R1 after reset");
    chk(vsync_halt, 1'b0, "R1 vsync_halt after");

    // Mode off: ticks and triggers do nothing
    tick_chk(1'b0, 1'b0, "R9 off tick");
    trig_ignored("R9 off trigger");

    // Enable the mode
    @(negedge clk) mode_en = 1'b1;
    @(negedge clk);
    chk(vsync_halt, 1'b1, "R2 halt on");
    for (int i = 0; i < 3; i++) begin
      tick_chk(1'b1, 1'b0, "R3 armed tick");
      idle_chk(1'b0, 1'b0, 1'b0, "R3 pulse width");
    end

    // Sweep every exposure length
    for (int n = 0; n < 16; n++) begin
      automatic int eff = (n == 0) ? 1 : n;
      automatic logic [W-1:0] nv = n[W-1:0];
      expo_lines = nv;
      trig_accept($sformatf("n=%0d", n));
      expo_lines = ~nv;   // R7: must not alter this exposure
      for (int k = 1; k <= eff; k++) begin
        if (k == 1 && eff >= 2) trig_ignored("R8 mid-exposure trigger");
        tick_chk(1'b0, (k == eff), $sformatf("R6 R7 R5 n=%0d line=%0d", n, k));
      end
      idle_chk(1'b0, 1'b0, 1'b0, "R6 single pulse");
      tick_chk(1'b1, 1'b0, "R8 re-armed");
      chk(vsync_halt, 1'b1, "R2 halt held");
    end

    // Abort an exposure by dropping the mode
    expo_lines = 4'd3;
    trig_accept("abort");
    tick_chk(1'b0, 1'b0, "R5 abort line1");
    @(negedge clk) mode_en = 1'b0;
    @(negedge clk);
    chk(vsync_halt, 1'b0, "R2 halt off");
    tick_chk(1'b0, 1'b0, "R9 aborted tick");
    tick_chk(1'b0, 1'b0, "R9 aborted tick2");
    @(negedge clk) mode_en = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 3; i++) tick_chk(1'b1, 1'b0, "R9 re-enabled armed");
    trig_accept("after abort");
    for (int k = 1; k <= 3; k++) tick_chk(1'b0, (k == 3), "R6 after abort");

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule